// File: doc/BRIEF.md
# Single-Port Sequential Register Read Control

This block is the issue-side controller for a register file that offers only one read port per issue slot. Each cycle, every slot may accept an instruction with zero, one or two register sources. For each source the scheduler supplies two flags: whether a producer woke the source in the same cycle the instruction was selected, and whether the source was already available when the instruction entered the window. A source woken back-to-back comes from the one-cycle bypass path. Every other source has to be fetched through the slot's single read port.

When at most one source needs the port, the operands are delivered one cycle after issue. The destination tag is announced in that same cycle. When both sources need the port, the controller reads the left source first and captures it in the slot's operand latch. It reads the right source in the following cycle. In that case operand delivery and the tag broadcast move one cycle later, and the slot refuses new issue for one cycle. Other slots carry on unaffected. The controller drives the read addresses, the operand source selects, the latch enable, the broadcast strobe and a combinational per-slot busy signal to the select logic. The register array and the execution units are outside this block.

Top module: `seqrd_ctrl`

## Requirements
- R1: An accepted instruction with no register source (source count 0) uses no read, and its operands are valid (both selects 0 = none) one cycle after issue.
- R2: An accepted one-source instruction (count 1) uses only the left operand. It reads the left address through the port one cycle after issue, unless the left source was woken back-to-back, in which case its select is 2 = bypass. The right select is 0.
- R3: A two-source instruction (count 2 or 3) with exactly one source woken back-to-back reads the other source through the port. Both operands are valid one cycle after issue, with selects 1 = port and 2 = bypass as appropriate.
- R4: A two-source instruction with both sources woken back-to-back makes no read, and both selects are 2 one cycle after issue.
- R5: A two-source instruction with both sources needing the port has two phases. One cycle after issue, the controller reads the left address with the latch enable high and operands not yet valid. Two cycles after issue, it reads the right address with the operands valid, left select 3 = latch and right select 1 = port.
- R6: A source marked ready at insert always reads through the port, even if its woken flag is also set.
- R7: The destination tag broadcast strobe rises together with operand validity: one cycle after issue for single reads, two cycles after for sequential reads. It carries the issued destination tag.
- R8: The busy signal of a slot is high in exactly the cycle after it accepts a sequential instruction. An issue attempt in that cycle is refused and produces no read, latch, operand or broadcast activity afterwards.
- R9: Each slot responds only to its own issue inputs. A slot with no accepted issue shows no activity, and all read address and tag outputs are 0 while their strobes are low.
- R10: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_vld | input | NSLOT | Issue attempt per slot |
| iss_nsrc | input | 2*NSLOT | Register source count per slot (2 or 3 mean two sources) |
| iss_src_a | input | AW*NSLOT | Left source register per slot |
| iss_src_b | input | AW*NSLOT | Right source register per slot |
| iss_dst | input | AW*NSLOT | Destination tag per slot |
| iss_woke_a | input | NSLOT | Left source woken in the selecting cycle |
| iss_woke_b | input | NSLOT | Right source woken in the selecting cycle |
| iss_rdy_a | input | NSLOT | Left source ready at insert |
| iss_rdy_b | input | NSLOT | Right source ready at insert |
| slot_busy | output | NSLOT | Slot refuses issue this cycle |
| rd_en | output | NSLOT | Read port enable per slot |
| rd_addr | output | AW*NSLOT | Read port address per slot |
| lat_en | output | NSLOT | Capture port data into the operand latch |
| opnd_vld | output | NSLOT | Operands are delivered this cycle |
| sel_a | output | 2*NSLOT | Left operand source: 0 none, 1 port, 2 bypass, 3 latch |
| sel_b | output | 2*NSLOT | Right operand source: 0 none, 1 port, 2 bypass, 3 latch |
| bc_vld | output | NSLOT | Destination tag broadcast strobe |
| bc_tag | output | AW*NSLOT | Broadcast destination tag |

## Verification
The assertions assume that the select logic honours the busy signal, so at most one instruction is in flight in a slot's read stage. They also assume that every input is a defined level at each clock edge. Neither assumption is enforced by the checks. The stimulus draws the issue valid, source count and all four flags freely, including the woken-plus-ready combination. It keeps issuing into busy slots, so that refusal is exercised rather than avoided. Directed cases place a sequential issue in one slot next to activity in the other slot.

// File: rtl/seqrd_pkg.sv
package seqrd_pkg;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_PORT  = 2'd1,
    SEL_BYP   = 2'd2,
    SEL_LATCH = 2'd3
  } opsel_e;

  // Read plan decided at issue time for one instruction.
  typedef struct packed {
    logic   seq;   // two reads through the single port
    logic   rd;    // at least one read in the first cycle
    logic   rd_b;  // the single read targets the right source
    opsel_e sa;
    opsel_e sb;
  } rdplan_t;

endpackage

// File: rtl/seqrd_rst_sync.sv
module seqrd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/seqrd_classify.sv
module seqrd_classify
  import seqrd_pkg::*;
(
  input  logic [1:0] nsrc,
  input  logic       woke_a,
  input  logic       woke_b,
  input  logic       rdy_a,
  input  logic       rdy_b,
  output rdplan_t    plan
);

  logic has_a, has_b, port_a, port_b;

  always_comb begin
    has_a  = (nsrc != 2'd0);
    has_b  = nsrc[1];
    // ready-at-insert wins over a back-to-back wakeup flag
    port_a = has_a && (rdy_a || !woke_a);
    port_b = has_b && (rdy_b || !woke_b);

    plan.seq  = port_a && port_b;
    plan.rd   = port_a || port_b;
    plan.rd_b = port_b && !port_a;
    if (!has_a)      plan.sa = SEL_NONE;
    else if (plan.seq) plan.sa = SEL_LATCH;
    else if (port_a) plan.sa = SEL_PORT;
    else             plan.sa = SEL_BYP;
    if (!has_b)      plan.sb = SEL_NONE;
    else if (port_b) plan.sb = SEL_PORT;
    else             plan.sb = SEL_BYP;
  end

endmodule

// File: rtl/seqrd_slot.sv
module seqrd_slot
  import seqrd_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_vld,
  input  logic [1:0]    iss_nsrc,
  input  logic [AW-1:0] iss_src_a,
  input  logic [AW-1:0] iss_src_b,
  input  logic [AW-1:0] iss_dst,
  input  logic          iss_woke_a,
  input  logic          iss_woke_b,
  input  logic          iss_rdy_a,
  input  logic          iss_rdy_b,
  output logic          busy,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          lat_en,
  output logic          opnd_vld,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic          bc_vld,
  output logic [AW-1:0] bc_tag
);

  rdplan_t       plan_d;
  logic          acc;
  logic          s1_vld_q, s1_vld_d;
  rdplan_t       s1_plan_q;
  logic [AW-1:0] s1_a_q, s1_b_q, s1_dst_q;
  logic          s2_vld_q, s2_vld_d, s2_en;
  logic [AW-1:0] s2_b_q, s2_dst_q;

  seqrd_classify u_cls (
    .nsrc   (iss_nsrc),
    .woke_a (iss_woke_a),
    .woke_b (iss_woke_b),
    .rdy_a  (iss_rdy_a),
    .rdy_b  (iss_rdy_b),
    .plan   (plan_d)
  );

  // next state
  always_comb begin
    busy     = s1_vld_q && s1_plan_q.seq;
    acc      = iss_vld && !busy;
    s1_vld_d = acc;
    s2_en    = busy;
    s2_vld_d = busy;
  end

  // registers: valid bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q <= 1'b0;
      s2_vld_q <= 1'b0;
    end else begin
      s1_vld_q <= s1_vld_d;
      s2_vld_q <= s2_vld_d;
    end
  end

  // registers: payload with clock enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_plan_q <= '0;
      s1_a_q    <= '0;
      s1_b_q    <= '0;
      s1_dst_q  <= '0;
      s2_b_q    <= '0;
      s2_dst_q  <= '0;
    end else begin
      if (acc) begin
        s1_plan_q <= plan_d;
        s1_a_q    <= iss_src_a;
        s1_b_q    <= iss_src_b;
        s1_dst_q  <= iss_dst;
      end
      if (s2_en) begin
        s2_b_q   <= s1_b_q;
        s2_dst_q <= s1_dst_q;
      end
    end
  end

  // read stage outputs
  always_comb begin
    rd_en    = 1'b0;
    rd_addr  = '0;
    lat_en   = 1'b0;
    opnd_vld = 1'b0;
    sel_a    = SEL_NONE;
    sel_b    = SEL_NONE;
    bc_vld   = 1'b0;
    bc_tag   = '0;
    if (s2_vld_q) begin
      rd_en    = 1'b1;
      rd_addr  = s2_b_q;
      opnd_vld = 1'b1;
      sel_a    = SEL_LATCH;
      sel_b    = SEL_PORT;
      bc_vld   = 1'b1;
      bc_tag   = s2_dst_q;
    end else if (s1_vld_q) begin
      rd_en  = s1_plan_q.rd;
      if (s1_plan_q.rd) rd_addr = s1_plan_q.rd_b ? s1_b_q : s1_a_q;
      lat_en = s1_plan_q.seq;
      if (!s1_plan_q.seq) begin
        opnd_vld = 1'b1;
        sel_a    = s1_plan_q.sa;
        sel_b    = s1_plan_q.sb;
        bc_vld   = 1'b1;
        bc_tag   = s1_dst_q;
      end
    end
  end

  // R5: a latch capture is followed by the second read that uses it
  p_second_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lat_en |=> (rd_en && opnd_vld && sel_a == SEL_LATCH && sel_b == SEL_PORT));

  // R5: latch select only right after a capture
  p_latch_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (opnd_vld && sel_a == SEL_LATCH) |-> $past(lat_en));

  // R7: broadcast held back in the capture cycle, sent in the next
  p_late_bcast_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lat_en |-> (!bc_vld ##1 bc_vld));

  // R7: operands and broadcast always coincide
  p_bcast_with_opnd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    opnd_vld |-> bc_vld);

  // R8: a busy cycle never starts a new capture in the following cycle
  p_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !lat_en);

  // R8: read stage and second-read stage never overlap
  p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(s1_vld_q && s2_vld_q));

endmodule

// File: rtl/seqrd_ctrl.sv
module seqrd_ctrl #(
  parameter int NSLOT = 2,
  parameter int AW    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSLOT-1:0]    iss_vld,
  input  logic [2*NSLOT-1:0]  iss_nsrc,
  input  logic [AW*NSLOT-1:0] iss_src_a,
  input  logic [AW*NSLOT-1:0] iss_src_b,
  input  logic [AW*NSLOT-1:0] iss_dst,
  input  logic [NSLOT-1:0]    iss_woke_a,
  input  logic [NSLOT-1:0]    iss_woke_b,
  input  logic [NSLOT-1:0]    iss_rdy_a,
  input  logic [NSLOT-1:0]    iss_rdy_b,
  output logic [NSLOT-1:0]    slot_busy,
  output logic [NSLOT-1:0]    rd_en,
  output logic [AW*NSLOT-1:0] rd_addr,
  output logic [NSLOT-1:0]    lat_en,
  output logic [NSLOT-1:0]    opnd_vld,
  output logic [2*NSLOT-1:0]  sel_a,
  output logic [2*NSLOT-1:0]  sel_b,
  output logic [NSLOT-1:0]    bc_vld,
  output logic [AW*NSLOT-1:0] bc_tag
);

  logic rst_n_sync;

  seqrd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    seqrd_slot #(.AW(AW)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n_sync),
      .iss_vld    (iss_vld[s]),
      .iss_nsrc   (iss_nsrc[2*s +: 2]),
      .iss_src_a  (iss_src_a[AW*s +: AW]),
      .iss_src_b  (iss_src_b[AW*s +: AW]),
      .iss_dst    (iss_dst[AW*s +: AW]),
      .iss_woke_a (iss_woke_a[s]),
      .iss_woke_b (iss_woke_b[s]),
      .iss_rdy_a  (iss_rdy_a[s]),
      .iss_rdy_b  (iss_rdy_b[s]),
      .busy       (slot_busy[s]),
      .rd_en      (rd_en[s]),
      .rd_addr    (rd_addr[AW*s +: AW]),
      .lat_en     (lat_en[s]),
      .opnd_vld   (opnd_vld[s]),
      .sel_a      (sel_a[2*s +: 2]),
      .sel_b      (sel_b[2*s +: 2]),
      .bc_vld     (bc_vld[s]),
      .bc_tag     (bc_tag[AW*s +: AW])
    );
  end

endmodule

// File: tb/seqrd_ctrl_bench.sv
`timescale 1ns/1ps
module seqrd_ctrl_bench;

  localparam int NS = 2;
  localparam int AW = 6;
  localparam int VW = 2*AW + 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NS-1:0]    iss_vld, iss_woke_a, iss_woke_b, iss_rdy_a, iss_rdy_b;
  logic [2*NS-1:0]  iss_nsrc;
  logic [AW*NS-1:0] iss_src_a, iss_src_b, iss_dst;
  logic [NS-1:0]    slot_busy, rd_en, lat_en, opnd_vld, bc_vld;
  logic [2*NS-1:0]  sel_a, sel_b;
  logic [AW*NS-1:0] rd_addr, bc_tag;

  seqrd_ctrl #(.NSLOT(NS), .AW(AW)) u_seqrd_ctrl (
    .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_nsrc(iss_nsrc),
    .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_dst(iss_dst),
    .iss_woke_a(iss_woke_a), .iss_woke_b(iss_woke_b),
    .iss_rdy_a(iss_rdy_a), .iss_rdy_b(iss_rdy_b),
    .slot_busy(slot_busy), .rd_en(rd_en), .rd_addr(rd_addr), .lat_en(lat_en),
    .opnd_vld(opnd_vld), .sel_a(sel_a), .sel_b(sel_b),
    .bc_vld(bc_vld), .bc_tag(bc_tag)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // model state per slot
  logic [VW-1:0] exp_v [NS];
  string         exp_l [NS];
  bit            m_busy [NS];
  bit            m_pend [NS];
  logic [AW-1:0] m_pb [NS], m_pd [NS];

  // {busy, rd_en, rd_addr, lat_en, opnd_vld, sel_a, sel_b, bc_vld, bc_tag}
  function automatic logic [VW-1:0] pack(bit b, bit re, logic [AW-1:0] ra, bit le,
                                         bit ov, logic [1:0] sa, logic [1:0] sb,
                                         bit bv, logic [AW-1:0] bt);
    return {b, re, ra, le, ov, sa, sb, bv, bt};
  endfunction

  function automatic logic [VW-1:0] observed(int s);
    return {slot_busy[s], rd_en[s], rd_addr[AW*s +: AW], lat_en[s], opnd_vld[s],
            sel_a[2*s +: 2], sel_b[2*s +: 2], bc_vld[s], bc_tag[AW*s +: AW]};
  endfunction

  task automatic check(string tag, logic [VW-1:0] act, logic [VW-1:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Builds next-cycle expectations from the driven inputs, then advances.
  task automatic step();
    logic [VW-1:0] nv [NS];
    string         nl [NS];
    bit            nb [NS];
    for (int s = 0; s < NS; s++) begin
      logic [1:0]    n  = iss_nsrc[2*s +: 2];
      logic [AW-1:0] a  = iss_src_a[AW*s +: AW];
      logic [AW-1:0] b  = iss_src_b[AW*s +: AW];
      logic [AW-1:0] d  = iss_dst[AW*s +: AW];
      bit two   = (n >= 2);
      bit one   = (n >= 1);
      bit pa    = one && (iss_rdy_a[s] || !iss_woke_a[s]);
      bit pb    = two && (iss_rdy_b[s] || !iss_woke_b[s]);
      bit hit6  = (one && iss_rdy_a[s] && iss_woke_a[s]) || (two && iss_rdy_b[s] && iss_woke_b[s]);
      nb[s] = 1'b0;
      if (m_pend[s]) begin
        nv[s] = pack(0, 1, m_pb[s], 0, 1, 2'd3, 2'd1, 1, m_pd[s]);
        nl[s] = "R5,R7 second read";
        m_pend[s] = 1'b0;
      end else if (iss_vld[s] && !m_busy[s]) begin
        if (pa && pb) begin
          nv[s] = pack(1, 1, a, 1, 0, 2'd0, 2'd0, 0, '0);
          nl[s] = hit6 ? "R6 first read" : "R5,R8 first read";
          nb[s] = 1'b1;
          m_pend[s] = 1'b1; m_pb[s] = b; m_pd[s] = d;
        end else begin
          logic [1:0] sa = !one ? 2'd0 : (pa ? 2'd1 : 2'd2);
          logic [1:0] sb = !two ? 2'd0 : (pb ? 2'd1 : 2'd2);
          logic [AW-1:0] ra = pa ? a : (pb ? b : '0);
          nv[s] = pack(0, pa || pb, ra, 0, 1, sa, sb, 1, d);
          if (hit6)          nl[s] = "R6 single";
          else if (!one)     nl[s] = "R1,R7 no source";
          else if (!two)     nl[s] = "R2,R7 one source";
          else if (pa || pb) nl[s] = "R3,R7 one bypass";
          else               nl[s] = "R4,R7 both bypass";
        end
      end else begin
        nv[s] = '0;
        nl[s] = (iss_vld[s] && m_busy[s]) ? "R8 refused issue" : "R9 idle slot";
      end
    end
    @(negedge clk);
    for (int s = 0; s < NS; s++) begin
      exp_v[s]  = nv[s];
      exp_l[s]  = nl[s];
      m_busy[s] = nb[s];
      check(exp_l[s], observed(s), exp_v[s]);
    end
  endtask

  task automatic drive_slot(int s, bit v, logic [1:0] n, logic [AW-1:0] a, logic [AW-1:0] b,
                            logic [AW-1:0] d, bit wa, bit wb, bit ra, bit rb);
    iss_vld[s] = v; iss_nsrc[2*s +: 2] = n;
    iss_src_a[AW*s +: AW] = a; iss_src_b[AW*s +: AW] = b; iss_dst[AW*s +: AW] = d;
    iss_woke_a[s] = wa; iss_woke_b[s] = wb; iss_rdy_a[s] = ra; iss_rdy_b[s] = rb;
  endtask

  task automatic idle_all();
    for (int s = 0; s < NS; s++) drive_slot(s, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'd2718));
    for (int s = 0; s < NS; s++) begin
      m_busy[s] = 0; m_pend[s] = 0; m_pb[s] = '0; m_pd[s] = '0;
    end
    // R10: reset holds outputs at zero even with issue attempts present
    for (int s = 0; s < NS; s++) drive_slot(s, 1, 2, 6'h11, 6'h22, 6'h33, 0, 0, 1, 1);
    repeat (3) @(negedge clk);
    for (int s = 0; s < NS; s++) check("R10 reset", observed(s), '0);
    idle_all();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int s = 0; s < NS; s++) check("R10 after release", observed(s), '0);

    // directed: slot0 sequential, slot1 zero-source alongside (R5, R9)
    drive_slot(0, 1, 2, 6'h05, 6'h0a, 6'h21, 0, 0, 1, 1);
    drive_slot(1, 1, 0, 6'h3f, 6'h3e, 6'h07, 0, 0, 0, 0);
    step();
    // slot0 busy: attempt refused (R8); slot1 issues a one-source (R2, R9)
    drive_slot(0, 1, 1, 6'h19, 6'h1a, 6'h2b, 0, 0, 0, 0);
    drive_slot(1, 1, 1, 6'h12, 6'h00, 6'h08, 0, 0, 0, 0);
    step();
    // R6: ready-at-insert with woken flag set on both sources
    drive_slot(0, 1, 3, 6'h31, 6'h32, 6'h33, 1, 1, 1, 1);
    drive_slot(1, 1, 2, 6'h14, 6'h15, 6'h16, 1, 0, 0, 0);
    step();
    drive_slot(0, 1, 2, 6'h01, 6'h02, 6'h03, 1, 1, 0, 0);
    drive_slot(1, 1, 2, 6'h24, 6'h25, 6'h26, 0, 1, 0, 0);
    step();
    drive_slot(0, 1, 1, 6'h0c, 6'h0d, 6'h0e, 1, 0, 0, 0);
    drive_slot(1, 0, 2, 6'h04, 6'h05, 6'h06, 0, 0, 1, 1);
    step();
    idle_all();
    step(); step();

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      for (int s = 0; s < NS; s++) begin
        int unsigned r = $urandom;
        drive_slot(s, (r[2:0] != 0), r[4:3], r[10:5], r[16:11], r[22:17],
                   r[23], r[24], r[25] & r[26], r[27] & r[28]);
      end
      step();
    end
    idle_all();
    step(); step();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule